// File: doc/BRIEF.md
# CPU Clock Source Switchover Controller

This block generates the CPU clock enable for a processor core. The enable comes from one of two sources. One is a fast main reference, which a programmable power-of-two ratio can slow down. The other is a slow subsystem oscillator, which reaches the block as a single-cycle `sub_tick` pulse already synchronized to the reference clock. Software writes a small control word that holds a ratio code and a source-select bit. The written word can be read back at once. The clock actually in use does not follow the write straight away: it changes only at the next instruction boundary of the clock that is running.

An instruction is `INSN_CLKS` pulses of the running CPU enable. When a boundary pulse arrives and the control word differs from the active setting, the block loads the new setting. It then holds the enable low for one reference cycle and restarts its counting from the new setting. A status bit reports the source that is really driving the CPU. A watchdog-run output is high only while the main clock is in use. One combined write is not allowed: switching from main to subsystem while also changing the ratio. That write applies only the source change and raises a sticky error flag.

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset the control word reads ratio code 4 with select 0 (main), `cfg_err` is 0, `src_status` is 0 and `wdt_run` is 1.
- R2: On the main clock, `cpu_ce` pulses once every 2^code reference cycles for ratio codes 0 to 4 (periods 1, 2, 4, 8, 16). Codes 5, 6 and 7 behave as code 4 (period 16).
- R3: On the subsystem clock, `cpu_ce` is high only in cycles where `sub_tick` is high. It follows every tick outside the switchover gap, whatever the ratio code holds.
- R4: A write is visible on `cfg_div`/`cfg_sel` in the next cycle. The active clock changes only at an instruction boundary. Between the write and the switchover, at most `INSN_CLKS` pulses of the old enable occur.
- R5: `src_status` (0 = main, 1 = subsystem) changes only in the cycle after a boundary pulse of the old enable.
- R6: In the first cycle after a switchover, `cpu_ce` is low. This holds whether the source or only the ratio changed.
- R7: `wdt_run` is 0 while `src_status` is 1, and 1 while it is 0.
- R8: A single write that changes the ratio code and switches from subsystem to main is legal. It applies both fields and leaves `cfg_err` unchanged.
- R9: A write with select 1, made while the stored select is 0 and carrying a ratio code that differs from the stored one, sets `cfg_err`. It sets the stored select to 1 and keeps the stored ratio code.
- R10: `cfg_err` stays at 1 until reset, through any later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle pulse per subsystem oscillator period |
| wr_en | input | 1 | Control word write strobe |
| wr_div | input | DIV_W | Ratio code to write |
| wr_sel | input | 1 | Source select to write (1 = subsystem) |
| cfg_div | output | DIV_W | Stored ratio code |
| cfg_sel | output | 1 | Stored source select |
| cfg_err | output | 1 | Sticky flag for a forbidden combined write |
| src_status | output | 1 | Source actually driving the CPU (1 = subsystem) |
| cpu_ce | output | 1 | CPU clock enable |
| wdt_run | output | 1 | Watchdog count enable |

## Verification
Each of the eight ratio codes is applied on the main clock, and enable pulses are counted over a 64-cycle window. This count separates the five real periods, and it also confirms that the three reserved codes fold onto the slowest period. A main-to-subsystem switch is measured from the write to the status flip, which shows where the switch lands on the instruction boundary and that the gap cycle is present. Runs on a steady subsystem tick are done with the ratio code changed in the middle, which shows that the ratio has no effect there. The legal and the forbidden combined writes are each applied, so their effects on the stored fields can be told apart. A long seeded random stretch of writes and ticks is then compared cycle by cycle with a reference model in the bench. That stretch finds ordering faults, such as a write landing on a boundary pulse.

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch #(
  parameter int DIV_W     = 3,
  parameter int MAX_LOG   = 4,
  parameter int INSN_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_tick,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_sel,
  output logic [DIV_W-1:0] cfg_div,
  output logic             cfg_sel,
  output logic             cfg_err,
  output logic             src_status,
  output logic             cpu_ce,
  output logic             wdt_run
);
  localparam int CNT_W = MAX_LOG;
  localparam int PH_W  = (INSN_CLKS > 1) ? $clog2(INSN_CLKS) : 1;
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(INSN_CLKS - 1);
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(MAX_LOG);

  function automatic logic [CNT_W-1:0] reload(input logic [DIV_W-1:0] code);
    if (int'(code) >= MAX_LOG) reload = '1;
    else reload = CNT_W'((1 << code) - 1);
  endfunction

  logic             use_sub, gap, csel, err;
  logic [DIV_W-1:0] act_div, cdiv;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  ph;

  wire pending  = (csel != use_sub) || (!csel && (cdiv != act_div));
  wire ce       = !gap && (use_sub ? sub_tick : (cnt == '0));
  wire boundary = ce && (ph == PH_LAST);
  wire illegal  = wr_en && wr_sel && !csel && (wr_div != cdiv);

  // control word: written immediately, forbidden combo keeps the ratio
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csel <= 1'b0;
      cdiv <= RST_DIV;
      err  <= 1'b0;
    end else if (wr_en) begin
      if (illegal) begin
        err  <= 1'b1;
        csel <= 1'b1;
      end else begin
        csel <= wr_sel;
        cdiv <= wr_div;
      end
    end
  end

  // active clock: switch only at an instruction boundary, then one idle cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_sub <= 1'b0;
      act_div <= RST_DIV;
      cnt     <= reload(RST_DIV);
      ph      <= '0;
      gap     <= 1'b0;
    end else if (gap) begin
      gap <= 1'b0;
    end else if (ce) begin
      if (boundary && pending) begin
        use_sub <= csel;
        act_div <= cdiv;
        cnt     <= reload(cdiv);
        ph      <= '0;
        gap     <= 1'b1;
      end else begin
        ph  <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        cnt <= reload(act_div);
      end
    end else if (!use_sub) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cfg_div    = cdiv;
  assign cfg_sel    = csel;
  assign cfg_err    = err;
  assign src_status = use_sub;
  assign cpu_ce     = ce;
  assign wdt_run    = !use_sub;

  assert_gap_after_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_status) |-> !cpu_ce);

  assert_switch_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_status) |-> $past(cpu_ce));

  assert_sub_ce_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_status && cpu_ce) |-> sub_tick);

  assert_main_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_status && cpu_ce && act_div != '0) |=> !cpu_ce);

  assert_illegal_keeps_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !cfg_sel && wr_div != cfg_div) |=>
      (cfg_div == $past(cfg_div) && cfg_sel && cfg_err));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: tb/sim_cpu_clk_switch.sv
module sim_cpu_clk_switch;
  localparam int CLK_PERIOD = 10;
  localparam int INSN = 2;

  logic clk = 0, rst_n = 0, sub_tick = 0, wr_en = 0, wr_sel = 0;
  logic [2:0] wr_div = 0;
  logic [2:0] cfg_div;
  logic cfg_sel, cfg_err, src_status, cpu_ce, wdt_run;

  cpu_clk_switch #(.DIV_W(3), .MAX_LOG(4), .INSN_CLKS(INSN)) u0 (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en), .wr_div(wr_div),
    .wr_sel(wr_sel), .cfg_div(cfg_div), .cfg_sel(cfg_sel), .cfg_err(cfg_err),
    .src_status(src_status), .cpu_ce(cpu_ce), .wdt_run(wdt_run));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  // reference model state
  int m_sub, m_div, m_cnt, m_ph, m_gap, m_csel, m_cdiv, m_err;
  // sampled outputs of the last step
  int s_ce, s_st, s_sel, s_div, s_err;

  function automatic int per(int code);
    return (code >= 4) ? 16 : (1 << code);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sub = 0; m_div = 4; m_cnt = 15; m_ph = 0; m_gap = 0;
    m_csel = 0; m_cdiv = 4; m_err = 0;
  endtask

  // one cycle: drive at negedge, compare, advance model to next posedge
  task automatic step(input bit we, input int wd, input bit ws, input bit tk);
    int e_ce, pend, bnd, n_sub, n_div, n_cnt, n_ph, n_gap, n_csel, n_cdiv, n_err;
    wr_en = we; wr_div = 3'(wd); wr_sel = ws; sub_tick = tk;
    #1;
    e_ce = (!m_gap && (m_sub ? tk : (m_cnt == 0))) ? 1 : 0;
    s_ce = int'(cpu_ce); s_st = int'(src_status); s_sel = int'(cfg_sel);
    s_div = int'(cfg_div); s_err = int'(cfg_err);
    check(s_ce == e_ce, m_sub ? "R3 cpu_ce" : "R2 cpu_ce", s_ce, e_ce);
    check(s_st == m_sub, "R5 src_status", s_st, m_sub);
    check(int'(wdt_run) == 1 - m_sub, "R7 wdt_run", int'(wdt_run), 1 - m_sub);
    check(s_sel == m_csel && s_div == m_cdiv, "R4 cfg word", s_sel*8 + s_div, m_csel*8 + m_cdiv);
    check(s_err == m_err, "R9 cfg_err", s_err, m_err);
    pend = (m_csel != m_sub) || (m_csel == 0 && m_cdiv != m_div);
    bnd = e_ce && (m_ph == INSN - 1);
    n_sub = m_sub; n_div = m_div; n_cnt = m_cnt; n_ph = m_ph; n_gap = m_gap;
    n_csel = m_csel; n_cdiv = m_cdiv; n_err = m_err;
    if (we) begin
      if (ws && m_csel == 0 && wd != m_cdiv) begin n_err = 1; n_csel = 1; end
      else begin n_csel = ws; n_cdiv = wd; end
    end
    if (m_gap) n_gap = 0;
    else if (e_ce) begin
      if (bnd && pend) begin
        n_sub = m_csel; n_div = m_cdiv; n_cnt = per(m_cdiv) - 1; n_ph = 0; n_gap = 1;
      end else begin
        n_ph = (m_ph == INSN - 1) ? 0 : m_ph + 1;
        n_cnt = per(m_div) - 1;
      end
    end else if (!m_sub) n_cnt = m_cnt - 1;
    m_sub = n_sub; m_div = n_div; m_cnt = n_cnt; m_ph = n_ph; m_gap = n_gap;
    m_csel = n_csel; m_cdiv = n_cdiv; m_err = n_err;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int tick_every);
    for (int i = 0; i < n; i++) step(0, 0, 0, (tick_every > 0) && (i % tick_every == 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt, tk, flips;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check(cfg_div == 3'd4 && cfg_sel == 0, "R1 cfg word", int'(cfg_div), 4);
    check(cfg_err == 0, "R1 cfg_err", int'(cfg_err), 0);
    check(src_status == 0 && wdt_run == 1, "R1 status/wdt", int'(src_status), 0);

    // R2 every ratio code on main
    for (int c = 0; c < 8; c++) begin
      step(1, c, 0, 0);
      idle(50, 0);
      cnt = 0;
      for (int i = 0; i < 64; i++) begin step(0, 0, 0, 0); cnt += s_ce; end
      check(cnt == 64 / per(c), "R2 pulse count", cnt, 64 / per(c));
    end

    // R4/R5/R6 main -> sub latency (ratio unchanged = legal)
    step(1, 7, 1, 0);
    step(0, 0, 0, 0);
    check(s_sel == 1, "R4 cfg_sel visible", s_sel, 1);
    cnt = s_ce; flips = 0;
    for (int i = 0; i < 200 && s_st == 0; i++) begin
      step(0, 0, 0, 0);
      if (s_st == 1) begin
        flips = 1;
        check(s_ce == 0, "R6 gap cycle", s_ce, 0);
      end else cnt += s_ce;
    end
    check(flips == 1, "R5 switch happened", flips, 1);
    check(cnt >= 1 && cnt <= INSN, "R4 old pulses before switch", cnt, INSN);

    // R3/R7 subsystem running, ratio changes ignored
    idle(20, 5);
    check(int'(wdt_run) == 0, "R7 wdt off in sub", int'(wdt_run), 0);
    cnt = 0; tk = 0;
    for (int i = 0; i < 100; i++) begin
      step(i == 40, 1, 1, i % 5 == 0);
      cnt += s_ce; tk += (i % 5 == 0);
    end
    check(cnt == tk, "R3 ce follows ticks", cnt, tk);
    check(s_st == 1 && s_err == 0, "R3 still sub after ratio write", s_st, 1);

    // R8 sub -> main with ratio change
    step(1, 1, 0, 0);
    idle(60, 5);
    check(s_st == 0 && s_err == 0, "R8 legal combined write", s_st * 2 + s_err, 0);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin step(0, 0, 0, 0); cnt += s_ce; end
    check(cnt == 32, "R8 new ratio applied", cnt, 32);

    // R9 forbidden main -> sub with ratio change
    step(1, 3, 1, 0);
    step(0, 0, 0, 0);
    check(s_err == 1 && s_sel == 1 && s_div == 1, "R9 err/sel/div", s_err*16 + s_sel*8 + s_div, 25);
    idle(30, 4);
    check(s_st == 1, "R9 source change applied", s_st, 1);

    // random stretch, model compared each cycle
    for (int i = 0; i < 4000; i++)
      step(($urandom % 25) == 0, $urandom % 8, $urandom % 2, ($urandom % 6) == 0);
    check(s_err == 1, "R10 err sticky", s_err, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule